// File: doc/BRIEF.md
# Direct-Mapped Read Cache Controller

This block is a read-only, direct-mapped cache placed between a processor load port and a slower, word-addressed backing memory. A load request carries a byte address. The controller splits that address into three fields. The index picks one of sixteen 64-byte lines. The tag is compared against the tag stored for that line. The word-select field picks one of the line's sixteen 32-bit words.

On a hit, the word is returned after a fixed lookup cost of two cycles and a data-array cost of three cycles. On a miss, the requester stays stalled. The controller issues a single burst request for the whole line, starting at word 0, and writes each arriving word into the data array. Only after the last word has arrived does it record the new tag and set the valid bit. It then reads the requested word out with the same three-cycle data cost.

An invalidate-all input empties the cache in one cycle. Only one request is in flight at a time. The requester sees `reqReady` low from acceptance until the single-cycle `respValid` pulse has been delivered.

Top module: `dmrc_top`

## Requirements
- R1: After reset, `reqReady` is 1 and both `respValid` and `memReq` are 0. The first access to any line after a reset is a miss.
- R2: Address bits [5:2] select the word within a line, bits [9:6] select the line and bits [31:10] form the tag. Bits [1:0] have no effect on the returned data.
- R3: When the indexed line is valid and its stored tag equals the request tag, the requested word appears on `respData` with `respValid` high exactly 5 cycles after the accepting clock edge, and `memReq` is not raised.
- R4: On a miss, `memReq` is high for exactly one cycle, 2 cycles after the accepting edge. At that time `memAddr` is the word address of word 0 of the line, that is request bits [31:6] followed by four zero bits.
- R5: The refill takes exactly 16 words on `memValid`, in order from word 0 to word 15. The line only reports a hit once the last word is in. The requested word is returned 3 cycles after the edge that takes the last word. With a memory that delivers the first word 50 cycles after the request and each later word 3 cycles after the previous one, the total latency of a miss is 101 cycles.
- R6: `reqReady` is low from the accepting edge until the response cycle has passed. `respValid` is a single-cycle pulse.
- R7: A miss on an index overwrites that line. A later access with the old tag at that index misses. Lines at other indices are unaffected and still hit.
- R8: A one-cycle pulse on `invalidateAll` clears every valid bit, so the next access to every line misses.
- R9: A hit raises no memory request, and a miss raises exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all valid bits |
| invalidateAll | input | 1 | One-cycle pulse that empties the whole cache |
| reqValid | input | 1 | Load request present |
| reqReady | output | 1 | Controller idle and able to accept a request |
| reqAddr | input | 32 | Byte address of the load |
| respValid | output | 1 | One-cycle pulse marking the returned word |
| respData | output | 32 | Returned 32-bit word |
| memReq | output | 1 | One-cycle burst request for a full line |
| memAddr | output | 30 | Word address of the first word of the line being fetched |
| memValid | input | 1 | A refill word is present on memData |
| memData | input | 32 | Refill word from memory |

## Verification
A stale valid bit, or one that was never cleared, shows up at the very next access to that index. The bench sees a 5-cycle response where 101 cycles are due, and the returned word comes from the wrong block. A fault in the tag store shows up the same way on the first access with a different tag at that index. A fault in the refill word counter or the write indexing does not show in the miss itself when the requested word happens to land correctly. It does show within the next sixteen hits to that line, as a wrong word at some word offset. For that reason every line is read back completely after it is filled. A timing fault in the control sequence shows at once as a wrong latency or a wrong position of the memory request.

// File: rtl/dmrc_pkg.sv
package dmrc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_MREQ,
    ST_FILL,
    ST_READ,
    ST_RESP
  } dmrc_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureReq;  // latch the request address
    logic dropLine;    // miss decided: clear valid of indexed line, reset fill counter
    logic fillWrite;   // write one refill word into the data array
    logic installTag;  // last refill word: record tag, set valid
    logic loadResp;    // read the requested word into the response register
  } dmrc_strobe_t;

endpackage

// File: rtl/dmrc_datapath.sv
module dmrc_datapath
  import dmrc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int NUM_LINES  = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          invalidateAll,
  input  dmrc_strobe_t                  stb,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [WORD_W-1:0]             memData,
  output logic                          lineHit,
  output logic                          fillLast,
  output logic [ADDR_W-$clog2(WORD_W/8)-1:0] memAddr,
  output logic [WORD_W-1:0]             respData
);

  localparam int BYTE_OFF_W = $clog2(WORD_W / 8);
  localparam int WORDS      = LINE_BYTES / (WORD_W / 8);
  localparam int WSEL_W     = $clog2(WORDS);
  localparam int IDX_W      = $clog2(NUM_LINES);
  localparam int TAG_W      = ADDR_W - IDX_W - WSEL_W - BYTE_OFF_W;
  localparam int WADDR_W    = ADDR_W - BYTE_OFF_W;
  localparam int DEPTH      = NUM_LINES * WORDS;

  logic [WADDR_W-1:0] reqWordAddr;
  logic [TAG_W-1:0]   reqTag;
  logic [IDX_W-1:0]   reqIdx;
  logic [WSEL_W-1:0]  reqWord;
  logic [WSEL_W-1:0]  fillIdx;

  logic [NUM_LINES-1:0] validBits;
  logic [TAG_W-1:0]     tagMem  [NUM_LINES];
  logic [WORD_W-1:0]    dataMem [DEPTH];

  // Byte lane bits never reach the storage.
  logic byteLaneUnused;
  assign byteLaneUnused = ^reqAddr[BYTE_OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      reqWordAddr <= '0;
    end else if (stb.captureReq) begin
      reqWordAddr <= reqAddr[ADDR_W-1:BYTE_OFF_W];
    end
  end

  assign reqTag  = reqWordAddr[WADDR_W-1 -: TAG_W];
  assign reqIdx  = reqWordAddr[WSEL_W +: IDX_W];
  assign reqWord = reqWordAddr[WSEL_W-1:0];

  // One valid flop per line so invalidate clears all in a single cycle.
  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    always_ff @(posedge clk) begin
      if (rst || invalidateAll) begin
        validBits[g] <= 1'b0;
      end else if (stb.dropLine && (reqIdx == IDX_W'(g))) begin
        validBits[g] <= 1'b0;
      end else if (stb.installTag && (reqIdx == IDX_W'(g))) begin
        validBits[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.installTag) begin
      tagMem[reqIdx] <= reqTag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fillIdx <= '0;
    end else if (stb.dropLine) begin
      fillIdx <= '0;
    end else if (stb.fillWrite) begin
      fillIdx <= fillIdx + WSEL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.fillWrite) begin
      dataMem[{reqIdx, fillIdx}] <= memData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      respData <= '0;
    end else if (stb.loadResp) begin
      respData <= dataMem[{reqIdx, reqWord}];
    end
  end

  assign lineHit  = validBits[reqIdx] && (tagMem[reqIdx] == reqTag);
  assign fillLast = (fillIdx == WSEL_W'(WORDS - 1));
  assign memAddr  = {reqTag, reqIdx, {WSEL_W{1'b0}}};

  AST_INSTALL_HITS: assert property (@(posedge clk) disable iff (rst)
    (stb.installTag && !invalidateAll) |=> lineHit) else $error("install did not produce hit"); // R5

  AST_FILL_NEVER_HITS: assert property (@(posedge clk) disable iff (rst)
    stb.fillWrite |-> !lineHit) else $error("partly filled line reports hit"); // R5

  AST_INVAL_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    invalidateAll |=> (validBits == '0)) else $error("invalidate left a valid line"); // R8

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    stb.dropLine |=> !lineHit) else $error("missed line still valid"); // R7

endmodule

// File: rtl/dmrc_ctrl.sv
module dmrc_ctrl
  import dmrc_pkg::*;
#(
  parameter int LOOKUP_CYC = 2,
  parameter int DATA_CYC   = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reqValid,
  input  logic         memValid,
  input  logic         lineHit,
  input  logic         fillLast,
  output logic         reqReady,
  output logic         respValid,
  output logic         memReq,
  output dmrc_strobe_t stb
);

  localparam int MAX_CYC = (LOOKUP_CYC > DATA_CYC) ? LOOKUP_CYC : DATA_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC) + 1;

  dmrc_state_e state;
  logic [CNT_W-1:0] cnt;
  logic cntDone;

  assign cntDone = (cnt == '0);

  always_comb begin
    stb            = '0;
    stb.captureReq = (state == ST_IDLE) && reqValid;
    stb.dropLine   = (state == ST_LOOKUP) && cntDone && !lineHit;
    stb.fillWrite  = (state == ST_FILL) && memValid;
    stb.installTag = (state == ST_FILL) && memValid && fillLast;
    stb.loadResp   = (state == ST_READ) && cntDone;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state <= ST_LOOKUP;
            cnt   <= CNT_W'(LOOKUP_CYC - 1);
          end
        end
        ST_LOOKUP: begin
          if (cntDone) begin
            if (lineHit) begin
              state <= ST_READ;
              cnt   <= CNT_W'(DATA_CYC - 1);
            end else begin
              state <= ST_MREQ;
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_MREQ: state <= ST_FILL;
        ST_FILL: begin
          if (memValid && fillLast) begin
            state <= ST_READ;
            cnt   <= CNT_W'(DATA_CYC - 1);
          end
        end
        ST_READ: begin
          if (cntDone) begin
            state <= ST_RESP;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqReady  = (state == ST_IDLE);
  assign respValid = (state == ST_RESP);
  assign memReq    = (state == ST_MREQ);

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
    respValid |=> !respValid) else $error("response longer than one cycle"); // R6

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> !reqReady) else $error("ready high after accept"); // R6

  AST_MEMREQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    memReq |=> !memReq) else $error("memory request longer than one cycle"); // R9

  AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_LOOKUP) && cntDone && lineHit) |=> !memReq) else $error("fetch on hit"); // R3

  AST_MISS_FETCHES: assert property (@(posedge clk) disable iff (rst)
    stb.dropLine |=> memReq) else $error("miss without fetch"); // R4

endmodule

// File: rtl/dmrc_top.sv
module dmrc_top
  import dmrc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int NUM_LINES  = 16,
  parameter int LOOKUP_CYC = 2,
  parameter int DATA_CYC   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 invalidateAll,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [ADDR_W-1:0]    reqAddr,
  output logic                 respValid,
  output logic [WORD_W-1:0]    respData,
  output logic                 memReq,
  output logic [ADDR_W-$clog2(WORD_W/8)-1:0] memAddr,
  input  logic                 memValid,
  input  logic [WORD_W-1:0]    memData
);

  dmrc_strobe_t stb;
  logic lineHit;
  logic fillLast;

  dmrc_ctrl #(
    .LOOKUP_CYC(LOOKUP_CYC),
    .DATA_CYC  (DATA_CYC)
  ) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .memValid (memValid),
    .lineHit  (lineHit),
    .fillLast (fillLast),
    .reqReady (reqReady),
    .respValid(respValid),
    .memReq   (memReq),
    .stb      (stb)
  );

  dmrc_datapath #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .LINE_BYTES(LINE_BYTES),
    .NUM_LINES (NUM_LINES)
  ) uData (
    .clk          (clk),
    .rst          (rst),
    .invalidateAll(invalidateAll),
    .stb          (stb),
    .reqAddr      (reqAddr),
    .memData      (memData),
    .lineHit      (lineHit),
    .fillLast     (fillLast),
    .memAddr      (memAddr),
    .respData     (respData)
  );

endmodule

// File: tb/dmrc_top_test.sv
module dmrc_top_test;

  localparam int MEM_FIRST = 50;
  localparam int MEM_NEXT  = 3;
  localparam int LOOKUP    = 2;
  localparam int DATA      = 3;
  localparam int WORDS     = 16;
  localparam int HIT_LAT   = LOOKUP + DATA;
  localparam int MISS_LAT  = LOOKUP + 1 + MEM_FIRST + (WORDS - 1) * MEM_NEXT + DATA;

  logic        clk = 0;
  logic        rst;
  logic        invalidateAll;
  logic        reqValid;
  logic        reqReady;
  logic [31:0] reqAddr;
  logic        respValid;
  logic [31:0] respData;
  logic        memReq;
  logic [29:0] memAddr;
  logic        memValid;
  logic [31:0] memData;

  int tests = 0;
  int fails = 0;
  logic [29:0] memBase;

  always #5 clk = ~clk;

  dmrc_top uut (
    .clk(clk), .rst(rst), .invalidateAll(invalidateAll),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .respValid(respValid), .respData(respData),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData)
  );

  function automatic logic [31:0] memWord(input logic [29:0] wa);
    return ({2'b00, wa} * 32'h9E3779B1) ^ 32'hC3A50000;
  endfunction

  function automatic logic [31:0] mkAddr(input logic [21:0] tg, input int idx, input int w, input int b);
    return {tg, idx[3:0], w[3:0], b[1:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Backing memory: first word MEM_FIRST cycles after request, then every MEM_NEXT.
  initial begin
    memValid = 0;
    memData  = '0;
    forever begin
      @(negedge clk);
      if (memReq && !rst) begin
        memBase = memAddr;
        repeat (MEM_FIRST) @(negedge clk);
        for (int w = 0; w < WORDS; w++) begin
          memValid = 1;
          memData  = memWord(memBase + 30'(w));
          @(negedge clk);
          memValid = 0;
          if (w != WORDS - 1) repeat (MEM_NEXT - 1) @(negedge clk);
        end
      end
    end
  end

  task automatic doRead(input logic [31:0] a, input bit expHit, input string tg);
    int lat;
    int nReq;
    int reqAt;
    logic [29:0] seen;
    bit readyBad;
    logic [31:0] got;
    logic [31:0] expData;
    lat = 0; nReq = 0; reqAt = -1; seen = '0; readyBad = 0;
    while (!reqReady) @(negedge clk);
    reqValid = 1;
    reqAddr  = a;
    @(negedge clk);
    reqValid = 0;
    while (1) begin
      if (memReq) begin
        nReq++;
        reqAt = lat;
        seen  = memAddr;
      end
      if (respValid) break;
      if (reqReady) readyBad = 1;
      @(negedge clk);
      lat++;
      if (lat > 400) break;
    end
    got = respData;
    expData = memWord(a[31:2]);
    check(got == expData, {tg, " R2 data word"}, got, expData);
    if (expHit) begin
      check(lat == HIT_LAT, {tg, " R3 hit latency"}, lat, HIT_LAT);
      check(nReq == 0, {tg, " R9 no fetch on hit"}, nReq, 0);
    end else begin
      check(lat == MISS_LAT, {tg, " R5 miss latency"}, lat, MISS_LAT);
      check(nReq == 1, {tg, " R9 one fetch on miss"}, nReq, 1);
      check(reqAt == LOOKUP, {tg, " R4 fetch timing"}, reqAt, LOOKUP);
      check(seen == {a[31:6], 4'b0000}, {tg, " R4 fetch address"}, {2'b00, seen}, {2'b00, a[31:6], 4'b0000});
    end
    check(!readyBad, {tg, " R6 ready low while busy"}, readyBad, 0);
    @(negedge clk);
    check(!respValid, {tg, " R6 single-cycle response"}, respValid, 0);
  endtask

  localparam logic [21:0] TAG_A = 22'h15A3C;
  localparam logic [21:0] TAG_B = 22'h3FFFF;

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1; invalidateAll = 0; reqValid = 0; reqAddr = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(reqReady == 1, "R1 reset ready", reqReady, 1);
    check(respValid == 0, "R1 reset respValid", respValid, 0);
    check(memReq == 0, "R1 reset memReq", memReq, 0);

    // Fill every line, then read back every word with varying byte lanes.
    for (int i = 0; i < 16; i++) begin
      doRead(mkAddr(TAG_A, i, (i * 5) % 16, i % 4), 0, "R1 cold line");
      for (int w = 0; w < 16; w++)
        doRead(mkAddr(TAG_A, i, w, w % 4), 1, "R3 sweep");
    end

    // R2: byte lanes do not change the word.
    for (int b = 0; b < 4; b++)
      doRead(mkAddr(TAG_A, 9, 7, b), 1, "R2 byte lane");

    // R7: conflict at index 3.
    doRead(mkAddr(TAG_B, 3, 11, 0), 0, "R7 conflict fill");
    doRead(mkAddr(TAG_B, 3, 0, 0), 1, "R7 new block hit");
    doRead(mkAddr(TAG_A, 5, 2, 0), 1, "R7 other index kept");
    doRead(mkAddr(TAG_A, 3, 4, 0), 0, "R7 evicted block misses");
    doRead(mkAddr(22'h0, 3, 15, 0), 0, "R7 zero tag");
    doRead(mkAddr(22'h0, 3, 15, 3), 1, "R7 zero tag hit");

    // R8: invalidate all.
    @(negedge clk);
    invalidateAll = 1;
    @(negedge clk);
    invalidateAll = 0;
    for (int i = 0; i < 16; i++)
      doRead(mkAddr(TAG_A, i, 15 - i, 0), i == 3 ? 0 : 0, "R8 after invalidate");
    for (int i = 0; i < 16; i++)
      doRead(mkAddr(TAG_A, i, i, 1), 1, "R8 refilled");

    // R1: reset mid-run empties the cache.
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    doRead(mkAddr(TAG_A, 6, 6, 0), 0, "R1 after reset");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule